// File: doc/BRIEF.md
# Glitch-Tolerant Forwarded-Clock Serial Receiver

This block takes a serial data line together with the serial clock that the sender forwards alongside it. It samples both lines with a much faster system clock. Both lines travel through matching delay paths, so they are treated as being in phase. Each line first passes through its own synchronizer chain of equal depth. A pulse detector then finds each rising edge of the synchronized serial clock. The detector counts a pulse even when noise has reduced it to a single high sample. After each accepted edge it holds off for a short window, so a glitch inside one pulse cannot be counted twice.

For every accepted pulse the block takes a majority vote over three consecutive data samples and shifts the result in, most significant bit first. When a full word has arrived it presents the word with a one-cycle valid strobe. The first pulse after idle already carries data, and no training sequence is needed. If the serial clock stays low for too long, a partly received word is dropped, so that the next pulse starts a fresh word.

Top module: `fcrx_receiver`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears itself. After that edge `valid_o` is 0 and `word_o` is all zeros.
- R2: With a clean serial clock pattern of two high samples and three low samples per bit, each pulse supplies one bit. Bits fill `word_o` most significant bit first, and `word_o` changes only in a cycle where `valid_o` is high.
- R3: A serial clock pulse that is only one sample wide still counts as exactly one bit.
- R4: After an accepted rising edge, any further rising edge seen on the next BLANK_CYC samples (default 3) is ignored. A rising edge BLANK_CYC+1 or more samples later is accepted.
- R5: The data bit is the majority of the data samples taken at the detected rising edge and at the two samples that follow it. A single flipped sample among the three does not change the bit.
- R6: The first pulse after reset or after a long idle period is accepted and supplies the first bit of the word. No preamble is needed.
- R7: `valid_o` is high for exactly one cycle when the WORD_W-th bit has been taken. Let E be the clock edge that first samples the high level of that bit's clock pulse on `sclk_i`. Then `valid_o` is high after edge E+4.
- R8: A low run on the serial clock of more than IDLE_LIMIT consecutive samples (default 16) discards the partly received word. A low run of exactly IDLE_LIMIT samples keeps it.
- R9: A reset in the middle of a word discards the bits received so far.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk_i | input | 1 | Forwarded serial clock, asynchronous to `clk` |
| sdat_i | input | 1 | Serial data, in phase with `sclk_i` |
| word_o | output | WORD_W | Last completed word, most significant bit received first |
| valid_o | output | 1 | One-cycle strobe marking a new `word_o` |

## Verification
Each result is due at a fixed distance from the samples that cause it. The edge that first samples a pulse's high level is called E. The data bit for that pulse depends on the `sdat_i` samples at edges E, E+1 and E+2. Any word completed by that pulse appears at `word_o`, together with `valid_o`, after edge E+4.

The bench records the value of each input at every rising edge. At each falling edge it steps a behavioural model over the sample taken four edges earlier, and compares `valid_o` and `word_o` against the model's prediction for that cycle. This means every comparison lands on the exact cycle the latency above predicts. Separate per-scenario checks compare the list of received words against fixed literal values, including the cases at the idle boundary and the blanking boundary.

// File: rtl/fcrx_pkg.sv
package fcrx_pkg;

    localparam int unsigned DEF_WORD_W      = 8;
    localparam int unsigned DEF_BLANK_CYC   = 3;
    localparam int unsigned DEF_IDLE_LIMIT  = 16;
    localparam int unsigned DEF_SYNC_STAGES = 2;

    // Pair of oversampled serial lines carried together through the synchronizer.
    typedef struct packed {
        logic clk;
        logic dat;
    } line_t;

    // Events produced by the pulse detector for the shifter.
    typedef struct packed {
        logic rise;      // accepted serial clock pulse
        logic idle_clr;  // low run exceeded the idle limit
    } det_ev_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    // Bits needed to hold the values 0..n.
    function automatic int unsigned cnt_w(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/fcrx_sync.sv
module fcrx_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d_i;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[g] <= '0;
            else     stg[g] <= stg[g-1];
        end
    end

    assign q_o = stg[STAGES-1];

endmodule

// File: rtl/fcrx_pulse_det.sv
module fcrx_pulse_det
    import fcrx_pkg::*;
#(
    parameter int unsigned BLANK_CYC  = DEF_BLANK_CYC,
    parameter int unsigned IDLE_LIMIT = DEF_IDLE_LIMIT
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    sclk_s,
    output det_ev_t ev_o
);

    localparam int unsigned BW = cnt_w(BLANK_CYC);
    localparam int unsigned IW = cnt_w(IDLE_LIMIT);

    logic          prev_q;
    logic [BW-1:0] blank_q;
    logic [IW-1:0] low_run_q;
    logic          blanked;
    logic          low_full;

    assign blanked  = (blank_q != '0);
    assign low_full = (low_run_q == IW'(IDLE_LIMIT));

    always_comb begin
        ev_o.rise     = sclk_s & ~prev_q & ~blanked;
        ev_o.idle_clr = ~sclk_s & low_full;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q    <= 1'b0;
            blank_q   <= '0;
            low_run_q <= '0;
        end else begin
            prev_q <= sclk_s;
            if (ev_o.rise)    blank_q <= BW'(BLANK_CYC);
            else if (blanked) blank_q <= blank_q - 1'b1;
            if (sclk_s)         low_run_q <= '0;
            else if (!low_full) low_run_q <= low_run_q + 1'b1;
        end
    end

endmodule

// File: rtl/fcrx_shifter.sv
module fcrx_shifter
    import fcrx_pkg::*;
#(
    parameter int unsigned WORD_W = DEF_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  det_ev_t           ev_i,
    input  logic              sdat_s,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o
);

    localparam int unsigned CW = $clog2(WORD_W);

    logic              dat_d1, dat_d2;
    logic              take_d1, take_d2;
    logic [WORD_W-1:0] shreg_q;
    logic [WORD_W-1:0] shnext;
    logic [CW-1:0]     bcnt_q;
    logic              voted;

    // Vote over data at detection, detection+1 and detection+2.
    assign voted  = maj3(dat_d2, dat_d1, sdat_s);
    assign shnext = {shreg_q[WORD_W-2:0], voted};

    always_ff @(posedge clk) begin
        if (rst) begin
            dat_d1  <= 1'b0;
            dat_d2  <= 1'b0;
            take_d1 <= 1'b0;
            take_d2 <= 1'b0;
            shreg_q <= '0;
            bcnt_q  <= '0;
            word_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            dat_d1  <= sdat_s;
            dat_d2  <= dat_d1;
            take_d1 <= ev_i.rise;
            take_d2 <= take_d1;
            valid_o <= 1'b0;
            if (take_d2) begin
                shreg_q <= shnext;
                if (bcnt_q == CW'(WORD_W - 1)) begin
                    word_o  <= shnext;
                    valid_o <= 1'b1;
                    bcnt_q  <= '0;
                end else begin
                    bcnt_q <= bcnt_q + 1'b1;
                end
            end else if (ev_i.idle_clr) begin
                bcnt_q <= '0;
            end
        end
    end

endmodule

// File: rtl/fcrx_receiver.sv
module fcrx_receiver
    import fcrx_pkg::*;
#(
    parameter int unsigned WORD_W      = DEF_WORD_W,
    parameter int unsigned BLANK_CYC   = DEF_BLANK_CYC,
    parameter int unsigned IDLE_LIMIT  = DEF_IDLE_LIMIT,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_i,
    input  logic              sdat_i,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o
);

    line_t   line_raw;
    line_t   line_s;
    det_ev_t det_ev;

    assign line_raw.clk = sclk_i;
    assign line_raw.dat = sdat_i;

    fcrx_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  ($bits(line_t))
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (line_raw),
        .q_o (line_s)
    );

    fcrx_pulse_det #(
        .BLANK_CYC  (BLANK_CYC),
        .IDLE_LIMIT (IDLE_LIMIT)
    ) u_det (
        .clk    (clk),
        .rst    (rst),
        .sclk_s (line_s.clk),
        .ev_o   (det_ev)
    );

    fcrx_shifter #(
        .WORD_W (WORD_W)
    ) u_shift (
        .clk     (clk),
        .rst     (rst),
        .ev_i    (det_ev),
        .sdat_s  (line_s.dat),
        .word_o  (word_o),
        .valid_o (valid_o)
    );

endmodule

// File: rtl/fcrx_receiver_chk.sv
module fcrx_receiver_chk #(
    parameter int unsigned WORD_W    = 8,
    parameter int unsigned BLANK_CYC = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              rise,
    input logic              valid,
    input logic [WORD_W-1:0] word
);

    int unsigned since_rise;

    always_ff @(posedge clk) begin
        if (rst)                          since_rise <= BLANK_CYC;
        else if (rise)                    since_rise <= 0;
        else if (since_rise < BLANK_CYC)  since_rise <= since_rise + 1;
    end

    // R1: outputs are cleared after a reset edge
    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (!valid && word == '0));

    // R2: the word only changes together with the strobe
    assert_word_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !$stable(word) |-> valid);

    // R4: accepted edges are spaced beyond the blanking window
    assert_rise_spacing_R4: assert property (@(posedge clk) disable iff (rst)
        rise |-> (since_rise >= BLANK_CYC));

    // R7: strobe lasts one cycle
    assert_valid_single_R7: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    // R7: a strobe follows an accepted edge by a fixed pipeline depth
    assert_valid_latency_R7: assert property (@(posedge clk) disable iff (rst)
        valid |-> $past(rise, 3));

endmodule

bind fcrx_receiver fcrx_receiver_chk #(
    .WORD_W    (WORD_W),
    .BLANK_CYC (BLANK_CYC)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .rise  (det_ev.rise),
    .valid (valid_o),
    .word  (word_o)
);

// File: tb/fcrx_receiver_tb_top.sv
module fcrx_receiver_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam int BLANK      = 3;
    localparam int IDLE       = 16;
    localparam int MAXC       = 16384;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sclk_i = 1'b0;
    logic         sdat_i = 1'b0;
    logic [W-1:0] word_o;
    logic         valid_o;

    fcrx_receiver #(
        .WORD_W     (W),
        .BLANK_CYC  (BLANK),
        .IDLE_LIMIT (IDLE)
    ) dut_i (
        .clk     (clk),
        .rst     (rst),
        .sclk_i  (sclk_i),
        .sdat_i  (sdat_i),
        .word_o  (word_o),
        .valid_o (valid_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic cin [MAXC];
    logic din [MAXC];
    int   kk = 0;

    int m_last, m_bcnt, m_word, m_run;
    int got_q[$];

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Record what the DUT sampled at each rising edge.
    always @(posedge clk) begin
        if (rst) kk = 0;
        else if (kk < MAXC) begin
            cin[kk] = sclk_i;
            din[kk] = sdat_i;
            kk++;
        end
    end

    // Behavioural model stepped over the sample taken four edges earlier.
    always @(negedge clk) begin
        int j;
        bit ev;
        int ew;
        logic pc;
        logic b;
        if (rst) begin
            m_last = -100; m_bcnt = 0; m_word = 0; m_run = 0;
        end else if (kk > 0) begin
            j  = kk - 5;
            ev = 0;
            ew = 0;
            if (j >= 0) begin
                m_run = cin[j] ? 0 : m_run + 1;
                if (m_run > IDLE) m_bcnt = 0;
                pc = (j > 0) ? cin[j-1] : 1'b0;
                if (cin[j] && !pc && (j - m_last > BLANK)) begin
                    m_last = j;
                    b = (din[j] & din[j+1]) | (din[j] & din[j+2]) | (din[j+1] & din[j+2]);
                    m_word = ((m_word << 1) | int'(b)) & ((1 << W) - 1);
                    m_bcnt++;
                    if (m_bcnt == W) begin
                        ev = 1; ew = m_word; m_bcnt = 0;
                    end
                end
            end
            checks++;
            if (valid_o !== ev) begin
                fails++;
                $display("FAIL R7 cycle %0d valid actual=%0b expected=%0b", kk, valid_o, ev);
            end
            if (ev) begin
                checks++;
                if (word_o !== W'(ew)) begin
                    fails++;
                    $display("FAIL R2 cycle %0d word actual=%0h expected=%0h", kk, word_o, ew);
                end
            end
            if (valid_o === 1'b1) got_q.push_back(int'(word_o));
        end
    end

    task automatic put(input logic c, input logic d);
        @(negedge clk);
        sclk_i = c;
        sdat_i = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) put(1'b0, 1'b0);
    endtask

    // One bit: five clock samples, data held, optional flipped data sample.
    task automatic send_bit(input logic [0:4] cp, input logic b, input int flip);
        for (int i = 0; i < 5; i++) put(cp[i], (i == flip) ? ~b : b);
    endtask

    task automatic send_byte(input logic [0:4] cp, input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(cp, v[i], -1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; sclk_i = 1'b0; sdat_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        @(negedge clk);
        check_eq("R1 reset valid", int'(valid_o), 0);
        check_eq("R1 reset word", int'(word_o), 0);

        // R2 / R6: clean pulses, first pulse after reset carries data
        got_q.delete();
        send_byte(5'b11000, 8'hA5);
        send_byte(5'b11000, 8'h3C);
        idle(20);
        check_eq("R2 word count", got_q.size(), 2);
        if (got_q.size() == 2) begin
            check_eq("R6 first word", got_q[0], 'hA5);
            check_eq("R2 second word", got_q[1], 'h3C);
        end

        // R3: single-sample pulses
        got_q.delete();
        send_byte(5'b10000, 8'h96);
        idle(20);
        check_eq("R3 word count", got_q.size(), 1);
        if (got_q.size() == 1) check_eq("R3 word", got_q[0], 'h96);

        // R4: glitches inside the blanking window
        got_q.delete();
        for (int i = 7; i >= 0; i--)
            send_bit((i % 2) ? 5'b10100 : 5'b11010, 1'((8'h5A >> i) & 1), -1);
        idle(20);
        check_eq("R4 word count", got_q.size(), 1);
        if (got_q.size() == 1) check_eq("R4 word", got_q[0], 'h5A);

        // R5: one flipped data sample per bit, rotating position
        got_q.delete();
        for (int i = 7; i >= 0; i--)
            send_bit(5'b11000, 1'((8'hC3 >> i) & 1), i % 3);
        idle(20);
        check_eq("R5 word count", got_q.size(), 1);
        if (got_q.size() == 1) check_eq("R5 word", got_q[0], 'hC3);

        // R8: low run of exactly IDLE keeps the partial word
        got_q.delete();
        send_bit(5'b11000, 1'b1, -1);
        send_bit(5'b11000, 1'b0, -1);
        send_bit(5'b11000, 1'b1, -1);
        send_bit(5'b11000, 1'b1, -1);
        idle(IDLE - 3);
        send_bit(5'b11000, 1'b0, -1);
        send_bit(5'b11000, 1'b0, -1);
        send_bit(5'b11000, 1'b1, -1);
        send_bit(5'b11000, 1'b0, -1);
        idle(20);
        check_eq("R8 boundary count", got_q.size(), 1);
        if (got_q.size() == 1) check_eq("R8 boundary word", got_q[0], 'hB2);

        // R8: low run of IDLE+1 drops the partial word
        got_q.delete();
        for (int i = 0; i < 4; i++) send_bit(5'b11000, 1'b1, -1);
        idle(IDLE - 2);
        send_byte(5'b11000, 8'h81);
        idle(20);
        check_eq("R8 timeout count", got_q.size(), 1);
        if (got_q.size() == 1) check_eq("R8 timeout word", got_q[0], 'h81);

        // R9: reset mid-word discards partial bits
        got_q.delete();
        for (int i = 0; i < 4; i++) send_bit(5'b11000, 1'b1, -1);
        do_reset();
        @(negedge clk);
        check_eq("R1 reset valid again", int'(valid_o), 0);
        check_eq("R9 word cleared", int'(word_o), 0);
        send_byte(5'b11000, 8'h7E);
        idle(20);
        check_eq("R9 word count", got_q.size(), 1);
        if (got_q.size() == 1) check_eq("R9 word", got_q[0], 'h7E);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule